// File: doc/BRIEF.md
# Backplane Bus Agent Cycle Controller

This block runs the bus cycles of one agent on a shared parallel backplane. A local client hands it one transfer request: a start address, an item count, a direction and write data, one item at a time. The controller then wins ownership of the bus and runs the transfer. Ownership is decided in a resolution phase. Every contender drives its 4-bit arbitration ID onto a wired arbitration bus for a fixed two clocks, and the numerically highest ID wins. The winner acquires the bus and opens a transfer with a one-clock request phase, which carries the address and control.

A reply phase follows the request phase. In each clock the owner signals ready, and an item moves only in a clock where the replier's ready is also high. The owner flags its final item with an end-of-transfer marker. Once that item completes, the bus is released and the local client receives a success response.

An agent that loses arbitration keeps its request and competes again in the next arbitration cycle, once the bus is free. Any agent may raise the shared exception line. When it is raised, all arbitration or transfer activity is abandoned. The bus then passes through a one-clock signal phase and a one-clock recovery phase, during which this agent drives nothing. A client whose request was in flight gets an error response. A new arbitration may begin in the clock right after recovery.

Top module: `bus_agent_ctrl`

## Requirements
- R1: After synchronous reset, the controller drives no bus output (all strobes low, all buses zero), locReady is 1 and locDone is 0.
- R2: Once a request is held and the bus is neither busy nor in exception, the agent drives its own ID on busArbOut with busArbDrive high for exactly 2 consecutive clocks.
- R3: When busArbIn equals agentId in the last resolution clock, the next clock is a single-clock request phase: busAddrStrobe and busBusyOut are high, busAddrOut carries the held address and busWriteOut carries the direction (1 = write).
- R4: When busArbIn differs from agentId in the last resolution clock, the agent drives no request phase and arbitrates again once busBusyIn is low.
- R5: In the reply phase busOwnRdy is high every clock. An item completes, with locBeat high, only in a clock where busRepRdy is also high. Otherwise the same item is held.
- R6: The transfer carries locLen+1 items. busEot is high only while the final item is pending. After the final item completes, the bus is released, and in the next clock locDone is 1 with locErr 0.
- R7: For a write, busDataOut equals locWdata throughout the reply phase. For a read, locRdata holds the busDataIn value of the most recent completed item, from the clock after its completion.
- R8: An exception seen during resolution, request or reply aborts the transfer. No item completes in that clock. In the next clock every bus output is idle and locDone is 1 with locErr 1.
- R9: After an exception clock, the agent drives nothing for two clocks (signal phase and recovery phase). With a request pending and the bus free, arbitration starts in the clock right after recovery.
- R10: An exception that arrives while a request waits but is not yet arbitrating gives no response. The request is kept and arbitrated after recovery.
- R11: locReady is 0 while a request is held. A locReq in that time is ignored, and the held address is the one used.
- R12: Arbitration never starts in a clock after one where busBusyIn or excIn was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| agentId | input | IW | This agent's arbitration ID |
| locReq | input | 1 | Local transfer request, accepted when locReady is 1 |
| locReady | output | 1 | No request held; a new one may be issued |
| locAddr | input | AW | Transfer start address |
| locLen | input | LW | Item count minus one |
| locWrite | input | 1 | 1 = write, 0 = read |
| locWdata | input | DW | Write data for the current item |
| locBeat | output | 1 | An item completes in this clock |
| locRdata | output | DW | Last read item |
| locDone | output | 1 | One-clock response pulse |
| locErr | output | 1 | Response was an abort |
| busArbIn | input | IW | Resolved (highest) arbitration ID on the bus |
| busArbOut | output | IW | ID driven during resolution |
| busArbDrive | output | 1 | Agent is contending |
| busBusyIn | input | 1 | Another agent owns the bus |
| busBusyOut | output | 1 | This agent owns the bus |
| busAddrOut | output | AW | Address in the request phase |
| busAddrStrobe | output | 1 | Request phase strobe |
| busWriteOut | output | 1 | Direction while owning |
| busOwnRdy | output | 1 | Owner ready in the reply phase |
| busEot | output | 1 | Final item marker |
| busRepRdy | input | 1 | Replier ready |
| busDataOut | output | DW | Write data |
| busDataIn | input | DW | Read data |
| excIn | input | 1 | Bus exception line |

## Verification
Arbitration is tried both without opposition and against a contender with a higher ID. This shows whether the agent acts only on the resolved ID, and whether it retries only once the bus is released. Transfers are run with an immediate replier and with a stalling one, as both writes and reads. These cases show whether items advance on the joint handshake alone and whether the end marker falls on the last item. Exceptions are injected in the resolution phase, in the middle of a transfer, and while a request is only waiting. These three cases separate an abort with an error response from a request that is kept, and a new request issued during the signal phase checks that arbitration starts straight after recovery.

// File: rtl/bus_agent_pkg.sv
package bus_agent_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESOLVE,
    ST_REQUEST,
    ST_REPLY,
    ST_EXC,
    ST_RECOVER
  } agentState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic dropReq;
    logic clrResolve;
    logic stepResolve;
    logic clrItem;
    logic stepItem;
    logic respOk;
    logic respErr;
    logic driveArb;
    logic driveAddr;
    logic driveReply;
  } ctlStrobe_t;

endpackage

// File: rtl/bus_agent_dp.sv
module bus_agent_dp
  import bus_agent_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int IW      = 4,
  parameter int LW      = 4,
  parameter int RES_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  ctlStrobe_t    strb,
  input  logic [IW-1:0] agentId,
  input  logic          locReq,
  input  logic [AW-1:0] locAddr,
  input  logic [LW-1:0] locLen,
  input  logic          locWrite,
  input  logic [DW-1:0] locWdata,
  input  logic [IW-1:0] busArbIn,
  input  logic [DW-1:0] busDataIn,
  output logic          pending,
  output logic          resolveDone,
  output logic          arbWon,
  output logic          lastItem,
  output logic          locReady,
  output logic          locBeat,
  output logic [DW-1:0] locRdata,
  output logic          locDone,
  output logic          locErr,
  output logic [IW-1:0] busArbOut,
  output logic          busArbDrive,
  output logic          busBusyOut,
  output logic [AW-1:0] busAddrOut,
  output logic          busAddrStrobe,
  output logic          busWriteOut,
  output logic          busOwnRdy,
  output logic          busEot,
  output logic [DW-1:0] busDataOut
);

  logic [AW-1:0] addrReg;
  logic [LW-1:0] lenReg;
  logic          writeReg;
  logic [LW-1:0] itemIdx;
  logic [DW-1:0] rdataReg;
  logic          doneReg;
  logic          errReg;

  // held request
  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      addrReg  <= '0;
      lenReg   <= '0;
      writeReg <= 1'b0;
    end else if (strb.dropReq) begin
      pending <= 1'b0;
    end else if (locReq && !pending) begin
      pending  <= 1'b1;
      addrReg  <= locAddr;
      lenReg   <= locLen;
      writeReg <= locWrite;
    end
  end

  // resolution window counter
  generate
    if (RES_CYC > 1) begin : g_resCnt
      localparam int RCW = $clog2(RES_CYC);
      localparam logic [RCW-1:0] RES_LAST = RCW'(RES_CYC - 1);
      logic [RCW-1:0] resolveCnt;
      always_ff @(posedge clk) begin
        if (rst || strb.clrResolve) resolveCnt <= '0;
        else if (strb.stepResolve)  resolveCnt <= resolveCnt + 1'b1;
      end
      assign resolveDone = (resolveCnt == RES_LAST);
    end else begin : g_resOne
      assign resolveDone = 1'b1;
    end
  endgenerate

  // item counter, read capture, response
  always_ff @(posedge clk) begin
    if (rst) begin
      itemIdx  <= '0;
      rdataReg <= '0;
      doneReg  <= 1'b0;
      errReg   <= 1'b0;
    end else begin
      if (strb.clrItem)       itemIdx <= '0;
      else if (strb.stepItem) itemIdx <= itemIdx + 1'b1;
      if (strb.stepItem && !writeReg) rdataReg <= busDataIn;
      doneReg <= strb.respOk | strb.respErr;
      errReg  <= strb.respErr;
    end
  end

  assign arbWon   = (busArbIn == agentId);
  assign lastItem = (itemIdx == lenReg);

  assign locReady = !pending;
  assign locBeat  = strb.stepItem;
  assign locRdata = rdataReg;
  assign locDone  = doneReg;
  assign locErr   = errReg;

  assign busArbDrive   = strb.driveArb;
  assign busArbOut     = strb.driveArb ? agentId : '0;
  assign busAddrStrobe = strb.driveAddr;
  assign busAddrOut    = strb.driveAddr ? addrReg : '0;
  assign busBusyOut    = strb.driveAddr | strb.driveReply;
  assign busWriteOut   = (strb.driveAddr | strb.driveReply) & writeReg;
  assign busOwnRdy     = strb.driveReply;
  assign busEot        = strb.driveReply & lastItem;
  assign busDataOut    = (strb.driveReply && writeReg) ? locWdata : '0;

endmodule

// File: rtl/bus_agent_fsm.sv
module bus_agent_fsm
  import bus_agent_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pending,
  input  logic       resolveDone,
  input  logic       arbWon,
  input  logic       lastItem,
  input  logic       busBusyIn,
  input  logic       busRepRdy,
  input  logic       excIn,
  output ctlStrobe_t strb
);

  agentState_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (excIn) begin
          nextState = ST_EXC;
        end else if (pending && !busBusyIn) begin
          nextState       = ST_RESOLVE;
          strb.clrResolve = 1'b1;
        end
      end
      ST_RESOLVE: begin
        strb.driveArb = 1'b1;
        if (excIn) begin
          nextState    = ST_EXC;
          strb.respErr = 1'b1;
          strb.dropReq = 1'b1;
        end else if (resolveDone) begin
          if (arbWon) begin
            nextState    = ST_REQUEST;
            strb.clrItem = 1'b1;
          end else begin
            nextState = ST_IDLE;
          end
        end else begin
          strb.stepResolve = 1'b1;
        end
      end
      ST_REQUEST: begin
        strb.driveAddr = 1'b1;
        if (excIn) begin
          nextState    = ST_EXC;
          strb.respErr = 1'b1;
          strb.dropReq = 1'b1;
        end else begin
          nextState = ST_REPLY;
        end
      end
      ST_REPLY: begin
        strb.driveReply = 1'b1;
        if (excIn) begin
          nextState    = ST_EXC;
          strb.respErr = 1'b1;
          strb.dropReq = 1'b1;
        end else if (busRepRdy) begin
          strb.stepItem = 1'b1;
          if (lastItem) begin
            nextState    = ST_IDLE;
            strb.respOk  = 1'b1;
            strb.dropReq = 1'b1;
          end
        end
      end
      ST_EXC: begin
        nextState = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (pending && !busBusyIn && !excIn) begin
          nextState       = ST_RESOLVE;
          strb.clrResolve = 1'b1;
        end else begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/bus_agent_ctrl.sv
module bus_agent_ctrl
  import bus_agent_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int IW      = 4,
  parameter int LW      = 4,
  parameter int RES_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] agentId,
  input  logic          locReq,
  output logic          locReady,
  input  logic [AW-1:0] locAddr,
  input  logic [LW-1:0] locLen,
  input  logic          locWrite,
  input  logic [DW-1:0] locWdata,
  output logic          locBeat,
  output logic [DW-1:0] locRdata,
  output logic          locDone,
  output logic          locErr,
  input  logic [IW-1:0] busArbIn,
  output logic [IW-1:0] busArbOut,
  output logic          busArbDrive,
  input  logic          busBusyIn,
  output logic          busBusyOut,
  output logic [AW-1:0] busAddrOut,
  output logic          busAddrStrobe,
  output logic          busWriteOut,
  output logic          busOwnRdy,
  output logic          busEot,
  input  logic          busRepRdy,
  output logic [DW-1:0] busDataOut,
  input  logic [DW-1:0] busDataIn,
  input  logic          excIn
);

  ctlStrobe_t strb;
  logic pending, resolveDone, arbWon, lastItem;

  bus_agent_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pending     (pending),
    .resolveDone (resolveDone),
    .arbWon      (arbWon),
    .lastItem    (lastItem),
    .busBusyIn   (busBusyIn),
    .busRepRdy   (busRepRdy),
    .excIn       (excIn),
    .strb        (strb)
  );

  bus_agent_dp #(
    .AW(AW), .DW(DW), .IW(IW), .LW(LW), .RES_CYC(RES_CYC)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strb          (strb),
    .agentId       (agentId),
    .locReq        (locReq),
    .locAddr       (locAddr),
    .locLen        (locLen),
    .locWrite      (locWrite),
    .locWdata      (locWdata),
    .busArbIn      (busArbIn),
    .busDataIn     (busDataIn),
    .pending       (pending),
    .resolveDone   (resolveDone),
    .arbWon        (arbWon),
    .lastItem      (lastItem),
    .locReady      (locReady),
    .locBeat       (locBeat),
    .locRdata      (locRdata),
    .locDone       (locDone),
    .locErr        (locErr),
    .busArbOut     (busArbOut),
    .busArbDrive   (busArbDrive),
    .busBusyOut    (busBusyOut),
    .busAddrOut    (busAddrOut),
    .busAddrStrobe (busAddrStrobe),
    .busWriteOut   (busWriteOut),
    .busOwnRdy     (busOwnRdy),
    .busEot        (busEot),
    .busDataOut    (busDataOut)
  );

endmodule

// File: rtl/bus_agent_ctrl_chk.sv
module bus_agent_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] agentId,
  input logic          locBeat,
  input logic [DW-1:0] locRdata,
  input logic          locDone,
  input logic          locErr,
  input logic [IW-1:0] busArbIn,
  input logic [IW-1:0] busArbOut,
  input logic          busArbDrive,
  input logic          busBusyIn,
  input logic          busBusyOut,
  input logic [AW-1:0] busAddrOut,
  input logic          busAddrStrobe,
  input logic          busWriteOut,
  input logic          busOwnRdy,
  input logic          busEot,
  input logic [DW-1:0] busDataIn,
  input logic [DW-1:0] busDataOut,
  input logic          excIn
);

  logic anyDrive;
  assign anyDrive = busArbDrive | busAddrStrobe | busBusyOut | busOwnRdy | busEot |
                    busWriteOut | (|busArbOut) | (|busAddrOut) | (|busDataOut);

  assert_arb_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busArbDrive) && !excIn |=> busArbDrive);

  assert_arb_len_R2: assert property (@(posedge clk) disable iff (rst)
    busArbDrive && $past(busArbDrive) |=> !busArbDrive);

  assert_win_R3: assert property (@(posedge clk) disable iff (rst)
    busAddrStrobe |-> $past(busArbDrive) && ($past(busArbIn) == agentId));

  assert_req_once_R3: assert property (@(posedge clk) disable iff (rst)
    busAddrStrobe |=> !busAddrStrobe);

  assert_eot_own_R6: assert property (@(posedge clk) disable iff (rst)
    busEot |-> busOwnRdy && busBusyOut && !busAddrStrobe);

  assert_rdata_R7: assert property (@(posedge clk) disable iff (rst)
    locBeat && !busWriteOut |=> locRdata == $past(busDataIn));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    excIn |=> !anyDrive);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    locDone && locErr |-> $past(excIn));

  assert_recover_R9: assert property (@(posedge clk) disable iff (rst)
    $past(excIn, 2) |-> !anyDrive);

  assert_start_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(busArbDrive) |-> !$past(busBusyIn) && !$past(excIn));

endmodule

bind bus_agent_ctrl bus_agent_ctrl_chk #(.AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .agentId       (agentId),
  .locBeat       (locBeat),
  .locRdata      (locRdata),
  .locDone       (locDone),
  .locErr        (locErr),
  .busArbIn      (busArbIn),
  .busArbOut     (busArbOut),
  .busArbDrive   (busArbDrive),
  .busBusyIn     (busBusyIn),
  .busBusyOut    (busBusyOut),
  .busAddrOut    (busAddrOut),
  .busAddrStrobe (busAddrStrobe),
  .busWriteOut   (busWriteOut),
  .busOwnRdy     (busOwnRdy),
  .busEot        (busEot),
  .busDataIn     (busDataIn),
  .busDataOut    (busDataOut),
  .excIn         (excIn)
);

// File: tb/bus_agent_ctrl_tb.sv
module bus_agent_ctrl_tb;
  localparam int AW = 16, DW = 16, IW = 4, LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] agentId = 4'd5;
  logic [IW-1:0] otherId = '0;
  logic locReq = 1'b0, locWrite = 1'b0;
  logic [AW-1:0] locAddr = '0;
  logic [LW-1:0] locLen = '0;
  logic [DW-1:0] locWdata = '0, busDataIn = '0;
  logic busBusyIn = 1'b0, busRepRdy = 1'b0, excIn = 1'b0;
  logic locReady, locBeat, locDone, locErr;
  logic [DW-1:0] locRdata, busDataOut;
  logic [IW-1:0] busArbIn, busArbOut;
  logic busArbDrive, busBusyOut, busAddrStrobe, busWriteOut, busOwnRdy, busEot;
  logic [AW-1:0] busAddrOut;

  int nTests = 0, nFail = 0;

  always #5 clk = ~clk;

  // wired priority: highest contending ID
  assign busArbIn = (busArbDrive && agentId > otherId) ? agentId : otherId;

  bus_agent_ctrl u_dut (
    .clk(clk), .rst(rst), .agentId(agentId),
    .locReq(locReq), .locReady(locReady), .locAddr(locAddr), .locLen(locLen),
    .locWrite(locWrite), .locWdata(locWdata), .locBeat(locBeat), .locRdata(locRdata),
    .locDone(locDone), .locErr(locErr),
    .busArbIn(busArbIn), .busArbOut(busArbOut), .busArbDrive(busArbDrive),
    .busBusyIn(busBusyIn), .busBusyOut(busBusyOut), .busAddrOut(busAddrOut),
    .busAddrStrobe(busAddrStrobe), .busWriteOut(busWriteOut), .busOwnRdy(busOwnRdy),
    .busEot(busEot), .busRepRdy(busRepRdy), .busDataOut(busDataOut),
    .busDataIn(busDataIn), .excIn(excIn)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic quiet();
    return !(busArbDrive | busAddrStrobe | busBusyOut | busOwnRdy | busEot | busWriteOut |
             (|busArbOut) | (|busAddrOut) | (|busDataOut));
  endfunction

  task automatic issue(input logic [AW-1:0] a, input logic [LW-1:0] n, input logic w);
    locAddr = a; locLen = n; locWrite = w; locReq = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "bus idle", {31'd0, quiet()}, 1);
    chk("R1", "locReady", {31'd0, locReady}, 1);
    chk("R1", "locDone", {31'd0, locDone}, 0);
  endtask

  task automatic t_write();
    issue(16'h1234, 4'd2, 1'b1);
    locWdata = 16'hA000;
    chk("R11", "ready before", {31'd0, locReady}, 1);
    step(); locReq = 1'b0;
    chk("R11", "ready held", {31'd0, locReady}, 0);
    chk("R2", "no arb yet", {31'd0, busArbDrive}, 0);
    step();
    chk("R2", "arb clk1", {31'd0, busArbDrive}, 1);
    chk("R2", "arb id", {28'd0, busArbOut}, 5);
    step();
    chk("R2", "arb clk2", {31'd0, busArbDrive}, 1);
    step();
    chk("R3", "strobe", {31'd0, busAddrStrobe}, 1);
    chk("R3", "addr", {16'd0, busAddrOut}, 32'h1234);
    chk("R3", "write", {31'd0, busWriteOut}, 1);
    chk("R3", "busy", {31'd0, busBusyOut}, 1);
    chk("R2", "arb ended", {31'd0, busArbDrive}, 0);
    step();
    chk("R5", "own rdy", {31'd0, busOwnRdy}, 1);
    chk("R5", "no beat stalled", {31'd0, locBeat}, 0);
    chk("R6", "eot item0", {31'd0, busEot}, 0);
    chk("R7", "wdata0", {16'd0, busDataOut}, 32'hA000);
    step();
    chk("R3", "strobe once", {31'd0, busAddrStrobe}, 0);
    chk("R5", "own rdy stall", {31'd0, busOwnRdy}, 1);
    busRepRdy = 1'b1; #1;
    chk("R5", "beat", {31'd0, locBeat}, 1);
    step(); locWdata = 16'hA001; #1;
    chk("R7", "wdata1", {16'd0, busDataOut}, 32'hA001);
    chk("R6", "eot item1", {31'd0, busEot}, 0);
    step(); locWdata = 16'hA002; #1;
    chk("R6", "eot last", {31'd0, busEot}, 1);
    chk("R7", "wdata2", {16'd0, busDataOut}, 32'hA002);
    step(); busRepRdy = 1'b0;
    chk("R6", "done", {31'd0, locDone}, 1);
    chk("R6", "no err", {31'd0, locErr}, 0);
    chk("R6", "released", {31'd0, quiet()}, 1);
    step();
    chk("R6", "done pulse", {31'd0, locDone}, 0);
  endtask

  task automatic t_read();
    issue(16'h0040, 4'd1, 1'b0);
    step(); locReq = 1'b0;
    step(); step(); step();
    chk("R3", "read dir", {31'd0, busWriteOut}, 0);
    step(); busRepRdy = 1'b1; busDataIn = 16'h5A5A;
    chk("R7", "no wdata on read", {16'd0, busDataOut}, 0);
    step();
    chk("R7", "rdata0", {16'd0, locRdata}, 32'h5A5A);
    chk("R6", "eot read last", {31'd0, busEot}, 1);
    busDataIn = 16'hC3C3;
    step(); busRepRdy = 1'b0;
    chk("R7", "rdata1", {16'd0, locRdata}, 32'hC3C3);
    chk("R6", "read done", {31'd0, locDone}, 1);
    step();
  endtask

  task automatic t_lose();
    otherId = 4'd9;
    issue(16'h0777, 4'd0, 1'b1);
    step(); locReq = 1'b0;
    step();
    chk("R4", "contending", {31'd0, busArbDrive}, 1);
    step(); busBusyIn = 1'b1;
    step();
    chk("R4", "no request on loss", {31'd0, busAddrStrobe}, 0);
    chk("R4", "not owner", {31'd0, busBusyOut}, 0);
    step();
    chk("R12", "wait busy", {31'd0, busArbDrive}, 0);
    step();
    chk("R12", "wait busy2", {31'd0, busArbDrive}, 0);
    busBusyIn = 1'b0; otherId = '0;
    step();
    chk("R4", "retry", {31'd0, busArbDrive}, 1);
    step(); step();
    chk("R4", "retry addr", {16'd0, busAddrOut}, 32'h0777);
    busRepRdy = 1'b1;
    step(); step(); busRepRdy = 1'b0;
    chk("R4", "retry done", {31'd0, locDone & ~locErr}, 1);
  endtask

  task automatic t_exc_arb();
    issue(16'h0321, 4'd0, 1'b1);
    step(); locReq = 1'b0;
    step(); excIn = 1'b1;
    step(); excIn = 1'b0;
    chk("R8", "quiet", {31'd0, quiet()}, 1);
    chk("R8", "err resp", {30'd0, locDone, locErr}, 3);
    chk("R8", "req dropped", {31'd0, locReady}, 1);
    issue(16'h0999, 4'd0, 1'b1);
    step(); locReq = 1'b0;
    chk("R9", "recovery quiet", {31'd0, quiet()}, 1);
    chk("R9", "resp pulse", {31'd0, locDone}, 0);
    step();
    chk("R9", "arb right after recovery", {31'd0, busArbDrive}, 1);
    step(); step();
    chk("R9", "new addr", {16'd0, busAddrOut}, 32'h0999);
    busRepRdy = 1'b1;
    step(); step(); busRepRdy = 1'b0;
    chk("R9", "new done ok", {30'd0, locDone, locErr}, 2);
  endtask

  task automatic t_exc_xfer();
    issue(16'h0100, 4'd3, 1'b0);
    step(); locReq = 1'b0;
    step(); step(); step();
    step(); busRepRdy = 1'b1; busDataIn = 16'h1111;
    step(); excIn = 1'b1; busDataIn = 16'h2222; #1;
    chk("R8", "no beat on exc", {31'd0, locBeat}, 0);
    step(); excIn = 1'b0; busRepRdy = 1'b0;
    chk("R8", "xfer quiet", {31'd0, quiet()}, 1);
    chk("R8", "xfer err", {30'd0, locDone, locErr}, 3);
    chk("R8", "no capture", {16'd0, locRdata}, 32'h1111);
    step();
    chk("R9", "xfer recovery quiet", {31'd0, quiet()}, 1);
    step();
    chk("R8", "idle after", {31'd0, busArbDrive}, 0);
  endtask

  task automatic t_exc_idle();
    busBusyIn = 1'b1;
    issue(16'h0ABC, 4'd0, 1'b1);
    step(); issue(16'h0DEF, 4'd0, 1'b1);
    chk("R12", "busy blocks arb", {31'd0, busArbDrive}, 0);
    chk("R11", "not ready", {31'd0, locReady}, 0);
    step(); locReq = 1'b0; excIn = 1'b1;
    step(); excIn = 1'b0;
    chk("R10", "no resp", {31'd0, locDone}, 0);
    chk("R10", "quiet", {31'd0, quiet()}, 1);
    step();
    chk("R10", "kept", {31'd0, locReady}, 0);
    busBusyIn = 1'b0;
    step();
    chk("R10", "arb after recovery", {31'd0, busArbDrive}, 1);
    step(); step();
    chk("R11", "first addr kept", {16'd0, busAddrOut}, 32'h0ABC);
    busRepRdy = 1'b1;
    step(); step(); busRepRdy = 1'b0;
    chk("R10", "done ok", {30'd0, locDone, locErr}, 2);
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_write();   step();
    t_read();    step();
    t_lose();    step();
    t_exc_arb(); step();
    t_exc_xfer(); step();
    t_exc_idle(); step();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule